// File: doc/BRIEF.md
# Reset Vector Sequencer

This block produces the internal reset of a small 8-bit microcontroller core. A reset can come from the external active-low reset pin or from a watchdog request. The pin is synchronized and then accepted only after it has been low for a minimum number of clocks, so short glitches do nothing. Once every reset source has gone away, the block counts out an oscillator settling period. It then runs a fixed seven-step sequence that reads the two-byte reset vector from the top of the address space and presents it as the starting program counter. When the sequence ends, `core_run` rises and the core may fetch its first opcode.

The vector reads use a valid/ready request channel and a valid/ready response channel. A request holds `req_valid` and `req_addr` steady until `req_ready` is seen high at a clock edge. The block raises `rsp_ready` only in the two steps that wait for read data. A response is taken on an edge where `rsp_valid` and `rsp_ready` are both high. If either channel stalls, the sequence waits in that step, and each stalled cycle adds one cycle to the sequence. When `ctl_load` pulses, the core and its peripherals load the reset values of their control bits from `ctl_vals`.

Top module: `reset_vector_seq`

## Requirements
- R1: A low pulse on `rst_pin_n` that lasts fewer than PULSE_MIN (default 8) synchronized clock periods causes no reset, so `core_run` stays high throughout.
- R2: A pin low for PULSE_MIN or more clocks is accepted. `core_run` goes low three clock edges after the pin returns high, or earlier if the pin stays low longer.
- R3: With memory that never stalls, `core_run` rises at the (STAB_CYCLES+11)-th rising edge, counting from the first edge that samples the pin high again.
- R4: The sequence issues exactly two read requests. The first is to address 16'hFFFE (low byte) and the second is to 16'hFFFF (high byte). `req_valid` is never high for any other address.
- R5: When `core_run` rises, `pc_value` equals {byte read from 16'hFFFF, byte read from 16'hFFFE}, and it stays stable while `core_run` remains high.
- R6: A high `wdt_req` drops `core_run` at the next edge. After it falls, `core_run` rises at the (STAB_CYCLES+8)-th edge, counting from the first edge that samples it low.
- R7: A qualified pin reset during the stabilization count restarts the full count from its release.
- R8: A reset during the vector fetch aborts the fetch and restarts from stabilization. The final `pc_value` is the vector read in the restarted fetch.
- R9: `ctl_load` pulses for exactly one cycle per reset release. While it is high, `ctl_vals` = 6'b000110, laid out as {page_sel, g_flag, sub_clk_sel, periph_clk_en, svd_en, booster_en}.
- R10: `core_run` is low from reset acceptance until the sequence completes, and no request is issued while `core_run` is high.
- R11: While `req_valid` is high and `req_ready` is low, `req_valid` and `req_addr` hold. Each stalled cycle adds one cycle to the time until run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset of the sequencer's own flops |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_req | input | 1 | Watchdog reset request, synchronous, active high |
| req_valid | output | 1 | Vector read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 16 | Vector byte address |
| rsp_valid | input | 1 | Read data valid |
| rsp_ready | output | 1 | Block waits for read data |
| rsp_data | input | 8 | Read data byte |
| core_run | output | 1 | Core released and executing |
| pc_value | output | 16 | Start address for the program counter |
| ctl_load | output | 1 | One-cycle strobe to load control reset values |
| ctl_vals | output | 6 | Reset values of the control bits |

## Verification
The bench sweeps pin pulse widths from 1 to 12 clocks. A qualifier that counts off by one would reset on a 7-clock glitch or ignore an 8-clock pulse. Each accepted pulse is timed to the exact edge of `core_run`, so any extra or missing register in the synchronizer, the counter or the seven steps shows up as a wrong cycle count. Aborts are placed both inside the settling count and in the middle of the fetch, with a new vector loaded each time. A design that resumed instead of restarting would release too early or keep a stale vector. Stalls on the request channel check that the address is held and that the release is delayed by exactly the number of stalled cycles.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_STAB = 2'd1,
    ST_SEQ  = 2'd2,
    ST_RUN  = 2'd3
  } rvs_state_e;

  typedef struct packed {
    logic page_sel;
    logic g_flag;
    logic sub_clk_sel;
    logic periph_clk_en;
    logic svd_en;
    logic booster_en;
  } ctl_bits_t;

  localparam ctl_bits_t CTL_RESET = '{
    page_sel:      1'b0,
    g_flag:        1'b0,
    sub_clk_sel:   1'b0,
    periph_clk_en: 1'b1,
    svd_en:        1'b1,
    booster_en:    1'b0
  };

  localparam int unsigned SEQ_STEPS = 7;

endpackage

// File: rtl/rvs_pin_qual.sv
module rvs_pin_qual #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PULSE_MIN   = 8
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_n,
  output logic pin_hold
);
  localparam int unsigned CW = $clog2(PULSE_MIN + 1);
  localparam logic [CW-1:0] CMAX = CW'(PULSE_MIN);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          low_cnt;
  logic                   pin_s;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sync_q <= '1;
        else        sync_q <= pin_n;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      end
    end
  endgenerate

  assign pin_s = sync_q[SYNC_STAGES-1];

  // Saturating count of consecutive low samples
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)             low_cnt <= '0;
    else if (pin_s)         low_cnt <= '0;
    else if (low_cnt != CMAX) low_cnt <= low_cnt + 1'b1;
  end

  assign pin_hold = (low_cnt == CMAX);

endmodule

// File: rtl/rvs_stab_timer.sv
module rvs_stab_timer #(
  parameter int unsigned STAB_CYCLES = 262144
) (
  input  logic clk,
  input  logic por_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = $clog2(STAB_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STAB_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)   cnt <= '0;
    else if (!run) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LAST);

endmodule

// File: rtl/rvs_vec_fetch.sv
module rvs_vec_fetch #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  active,
  output logic                  done,
  output logic                  req_valid,
  input  logic                  req_ready,
  output logic [ADDR_W-1:0]     req_addr,
  input  logic                  rsp_valid,
  output logic                  rsp_ready,
  input  logic [DATA_W-1:0]     rsp_data,
  output logic [2*DATA_W-1:0]   pc_value
);
  localparam int unsigned SW = $clog2(rvs_pkg::SEQ_STEPS);
  localparam logic [SW-1:0] S_IDLE   = SW'(0);
  localparam logic [SW-1:0] S_REQ_LO = SW'(1);
  localparam logic [SW-1:0] S_RSP_LO = SW'(2);
  localparam logic [SW-1:0] S_REQ_HI = SW'(3);
  localparam logic [SW-1:0] S_RSP_HI = SW'(4);
  localparam logic [SW-1:0] S_LOAD   = SW'(5);
  localparam logic [SW-1:0] S_LAST   = SW'(rvs_pkg::SEQ_STEPS - 1);
  localparam logic [ADDR_W-1:0] VEC_HI = '1;
  localparam logic [ADDR_W-1:0] VEC_LO = VEC_HI - 1'b1;

  logic [SW-1:0]     step;
  logic              adv;
  logic [DATA_W-1:0] lo_q, hi_q;
  logic [2*DATA_W-1:0] pc_q;

  always_comb begin
    unique case (step)
      S_REQ_LO, S_REQ_HI: adv = req_ready;
      S_RSP_LO, S_RSP_HI: adv = rsp_valid;
      default:            adv = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                    step <= S_IDLE;
    else if (!active)              step <= S_IDLE;
    else if (adv && step != S_LAST) step <= step + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lo_q <= '0;
      hi_q <= '0;
      pc_q <= '0;
    end else if (active) begin
      if (step == S_RSP_LO && rsp_valid) lo_q <= rsp_data;
      if (step == S_RSP_HI && rsp_valid) hi_q <= rsp_data;
      if (step == S_LOAD)                pc_q <= {hi_q, lo_q};
    end
  end

  assign req_valid = active && (step == S_REQ_LO || step == S_REQ_HI);
  assign req_addr  = (step == S_REQ_HI) ? VEC_HI : VEC_LO;
  assign rsp_ready = active && (step == S_RSP_LO || step == S_RSP_HI);
  assign done      = active && (step == S_LAST);
  assign pc_value  = pc_q;

endmodule

// File: rtl/reset_vector_seq.sv
module reset_vector_seq #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PULSE_MIN   = 8,
  parameter int unsigned STAB_CYCLES = 262144,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 8
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                rst_pin_n,
  input  logic                wdt_req,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [ADDR_W-1:0]   req_addr,
  input  logic                rsp_valid,
  output logic                rsp_ready,
  input  logic [DATA_W-1:0]   rsp_data,
  output logic                core_run,
  output logic [2*DATA_W-1:0] pc_value,
  output logic                ctl_load,
  output logic [5:0]          ctl_vals
);
  import rvs_pkg::*;

  rvs_state_e state, state_nx;
  logic pin_hold, src, stab_done, fetch_done, load_q;

  rvs_pin_qual #(.SYNC_STAGES(SYNC_STAGES), .PULSE_MIN(PULSE_MIN)) u_qual (
    .clk(clk), .por_n(por_n), .pin_n(rst_pin_n), .pin_hold(pin_hold)
  );

  rvs_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
    .clk(clk), .por_n(por_n), .run(state == ST_STAB), .done(stab_done)
  );

  rvs_vec_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fetch (
    .clk(clk), .por_n(por_n), .active(state == ST_SEQ), .done(fetch_done),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .pc_value(pc_value)
  );

  assign src = pin_hold || wdt_req;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_HOLD: if (!src) state_nx = ST_STAB;
      ST_STAB: if (src) state_nx = ST_HOLD; else if (stab_done)  state_nx = ST_SEQ;
      ST_SEQ:  if (src) state_nx = ST_HOLD; else if (fetch_done) state_nx = ST_RUN;
      default: if (src) state_nx = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state  <= ST_HOLD;
      load_q <= 1'b0;
    end else begin
      state  <= state_nx;
      load_q <= (state == ST_HOLD) && (state_nx == ST_STAB);
    end
  end

  assign core_run = (state == ST_RUN);
  assign ctl_load = load_q;
  assign ctl_vals = CTL_RESET;

endmodule

// File: rtl/rvs_checker.sv
module rvs_checker (
  input logic        clk,
  input logic        por_n,
  input logic        wdt_req,
  input logic        req_valid,
  input logic        req_ready,
  input logic [15:0] req_addr,
  input logic        core_run,
  input logic [15:0] pc_value,
  input logic        ctl_load
);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!por_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  assert_vec_addr_R4: assert property (@(posedge clk) disable iff (!por_n)
    req_valid |-> (req_addr == 16'hFFFE || req_addr == 16'hFFFF));

  assert_wdt_stops_R6: assert property (@(posedge clk) disable iff (!por_n)
    wdt_req |=> !core_run);

  assert_single_load_R9: assert property (@(posedge clk) disable iff (!por_n)
    ctl_load |=> !ctl_load);

  assert_pc_held_R5: assert property (@(posedge clk) disable iff (!por_n)
    (core_run && $past(core_run)) |-> $stable(pc_value));

  assert_no_req_run_R10: assert property (@(posedge clk) disable iff (!por_n)
    core_run |-> !req_valid);
endmodule

bind reset_vector_seq rvs_checker u_rvs_checker (
  .clk(clk), .por_n(por_n), .wdt_req(wdt_req), .req_valid(req_valid),
  .req_ready(req_ready), .req_addr(req_addr), .core_run(core_run),
  .pc_value(pc_value), .ctl_load(ctl_load)
);

// File: tb/test_reset_vector_seq.sv
module test_reset_vector_seq;
  localparam int STAB = 16;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic rst_pin_n = 1'b1;
  logic wdt_req = 1'b0;
  logic req_valid, req_ready = 1'b1, rsp_valid = 1'b0, rsp_ready;
  logic [15:0] req_addr, pc_value;
  logic [7:0]  rsp_data = 8'h00;
  logic core_run, ctl_load;
  logic [5:0] ctl_vals;

  int errors = 0, checks = 0;
  logic [7:0] mem_lo = 8'h34, mem_hi = 8'h12;
  int stall = 0, wcnt = 0, nreq = 0;
  logic [15:0] addr_log [0:3];

  always #2 clk = ~clk;

  reset_vector_seq #(.STAB_CYCLES(STAB)) i_reset_vector_seq (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .wdt_req(wdt_req),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .core_run(core_run), .pc_value(pc_value), .ctl_load(ctl_load),
    .ctl_vals(ctl_vals)
  );

  // memory responder: data one cycle after an accepted request
  always @(posedge clk) begin
    rsp_valid <= req_valid && req_ready;
    rsp_data  <= (req_addr == 16'hFFFF) ? mem_hi : mem_lo;
    if (req_valid && req_ready) begin
      if (nreq < 4) addr_log[nreq] = req_addr;
      nreq = nreq + 1;
    end
  end

  always @(negedge clk) begin
    if (req_valid && wcnt < stall) begin
      req_ready = 1'b0;
      wcnt = wcnt + 1;
    end else begin
      req_ready = 1'b1;
      if (!req_valid) wcnt = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // count edges until core_run rises after having been low
  task automatic measure(input int exp, input string tag);
    int k = 0;
    int loads = 0;
    bit low = 1'b0;
    bit done = 1'b0;
    while (!done && k < STAB + 80) begin
      @(posedge clk); k++;
      @(negedge clk);
      if (ctl_load) begin
        loads++;
        check(ctl_vals == 6'b000110, "R9 ctl_vals", ctl_vals, 6'b000110);
      end
      if (!core_run) low = 1'b1;
      else if (low) done = 1'b1;
    end
    check(k == exp, tag, k, exp);
    check(loads == 1, "R9 one ctl_load per release", loads, 1);
    check(pc_value == {mem_hi, mem_lo}, "R5 pc vector", pc_value, {mem_hi, mem_lo});
  endtask

  task automatic pin_pulse(input int n);
    rst_pin_n = 1'b0;
    repeat (n) @(negedge clk);
    rst_pin_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(core_run == 1'b0 && req_valid == 1'b0, "R10 reset state", core_run, 0);
    por_n = 1'b1;
    repeat (STAB + 10) @(negedge clk);
    check(core_run == 1'b1, "R3 run after power-on", core_run, 1);

    // pin pulse width sweep
    for (int n = 1; n <= 12; n++) begin
      mem_lo = 8'(8'h10 + n); mem_hi = 8'(8'hA0 + n); nreq = 0;
      pin_pulse(n);
      if (n < PMIN()) begin
        bit dropped = 1'b0;
        repeat (14) begin
          @(negedge clk);
          if (!core_run) dropped = 1'b1;
        end
        check(!dropped, "R1 short pulse ignored", dropped, 0);
        check(nreq == 0, "R1 no fetch", nreq, 0);
      end else begin
        measure(STAB + 11, "R2 R3 release to run");
        check(nreq == 2 && addr_log[0] == 16'hFFFE && addr_log[1] == 16'hFFFF,
              "R4 fetch order", {addr_log[0], addr_log[1]}, 32'hFFFEFFFF);
      end
      repeat (3) @(negedge clk);
    end

    // watchdog widths
    for (int w = 1; w <= 3; w++) begin
      mem_lo = 8'(8'h55 + w); mem_hi = 8'(8'h66 + w);
      wdt_req = 1'b1;
      @(negedge clk);
      check(core_run == 1'b0, "R6 watchdog drops run", core_run, 0);
      repeat (w - 1) @(negedge clk);
      wdt_req = 1'b0;
      measure(STAB + 8, "R6 watchdog release to run");
    end

    // abort during stabilization
    mem_lo = 8'h9C; mem_hi = 8'h3E;
    pin_pulse(10);
    repeat (5) @(negedge clk);
    pin_pulse(10);
    measure(STAB + 11, "R7 restart stabilization");

    // abort during vector fetch with new vector
    mem_lo = 8'h01; mem_hi = 8'h02;
    pin_pulse(9);
    repeat (STAB + 6) @(negedge clk);
    mem_lo = 8'hC3; mem_hi = 8'h7B;
    wdt_req = 1'b1;
    @(negedge clk);
    wdt_req = 1'b0;
    measure(STAB + 8, "R8 restart fetch");

    // request stalls
    for (int s = 1; s <= 3; s++) begin
      stall = s; mem_lo = 8'(8'h20 * s); mem_hi = 8'(8'h0F + s);
      pin_pulse(8);
      measure(STAB + 11 + 2 * s, "R11 stalled release");
    end
    stall = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic int PMIN();
    return 8;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule